// File: doc/BRIEF.md
# I2C EEPROM Access Sequencer

This block turns single host requests into the command sequences a serial EEPROM expects on an I2C bus. It sits in front of a byte-level I2C controller and issues one command at a time to it: start, stop, byte write and byte read. It then watches the controller's transfer-in-progress, acknowledge and arbitration-lost flags before it moves on. A host asks for a random single-byte read or for a write of any length. A write is cut at page boundaries into bursts. Each burst ends in a stop and is followed by a fixed programming wait.

Status polling uses backoff. The first sample is taken the cycle after a command is issued. Later samples follow waits that start at 32 µs and double on each retry. All retries for one command draw on one shared budget. If the budget runs out, or arbitration is lost, the block aborts: it sends a lone stop and reports an error. All wait times are derived from a clock-frequency parameter. A second parameter selects a larger device with 64-byte pages and two address bytes.

Top module: `eeprom_seq`

## Requirements
- R1: After reset, busy, done, cmd_valid and wr_take are all 0.
- R2: Every command with a start flag carries a device byte. In the 2 KB mode this byte is 0xA0 OR (addr[10:8] << 1) OR rw, where rw = 1 means a read. Start commands also have cmd_write = 1.
- R3: A read of a valid address issues exactly four commands, in this order:
  - start + device byte (rw=0);
  - a write of addr[7:0];
  - start + device byte (rw=1);
  - a read with nack and stop set and cmd_byte = 0.
  After these, rd_data holds the controller's received byte, and done pulses with err = 0.
- R4: A write burst issues three kinds of command, in this order:
  - start + device byte;
  - the low address byte;
  - one data byte per command, with stop set only on the burst's last byte.
  Each data byte is taken from wr_data in a cycle where wr_take pulses, and wr_take pulses once per byte.
- R5: A write is split into bursts of min(remaining, 16 − (addr mod 16)) bytes. Each burst starts at the running address.
- R6: After the last command of a burst, at least 6 ms (CLK_HZ·6/1000 cycles) pass before the next start or before done.
- R7: No command follows another until the controller reports transfer finished and the expected acknowledge. Two commands are never issued on consecutive cycles.
- R8: Status is sampled the cycle after a command is issued. Each failed sample waits 32 µs, then 64 µs, and so on, doubling each time (saturating). After MAX_POLLS retries with no success, whether the cause is a busy controller or a missing acknowledge, the block issues a stop-only command, and the next cycle done pulses with err = 1.
- R9: Arbitration lost at a status sample causes a stop-only command on the next cycle, then done with err = 1.
- R10: A read at an address ≥ 2048 is refused with no command issued: done and err = 1 one cycle after the request. The block then accepts new requests.
- R11: A write with length 0, or with addr + length > 2048, is refused the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = single-byte read |
| req_addr | input | 16 | Start byte address |
| req_len | input | LEN_W | Write length in bytes |
| wr_data | input | 8 | Current write byte from host |
| wr_take | output | 1 | Pulse: wr_data consumed, present next byte |
| rd_data | output | 8 | Byte returned by last read |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error, valid with done |
| cmd_valid | output | 1 | Command strobe to I2C controller |
| cmd_start | output | 1 | Generate (repeated) start |
| cmd_stop | output | 1 | Generate stop |
| cmd_write | output | 1 | Transmit cmd_byte |
| cmd_read | output | 1 | Receive one byte |
| cmd_nack | output | 1 | Answer received byte with NACK |
| cmd_byte | output | 8 | Byte to transmit |
| core_tip | input | 1 | Controller transfer in progress |
| core_rxack | input | 1 | Acknowledge bit seen (1 = no ack) |
| core_al | input | 1 | Arbitration lost |
| core_rdata | input | 8 | Byte received by controller |

## Verification
Errors in the sequencing state show up at the command port on the very next command. The byte value or the start, stop and nack flags come out wrong, or a command is missing or extra. A lost byte in the burst length or the running address shows up within one page, in the address byte of the next burst and in the number of wr_take pulses. Errors in the delay, budget or programming-wait counters do not change what is sent; they change the spacing between commands. That is why the spacing between logged commands is measured against the backoff and programming-wait figures.

// File: rtl/eeprom_seq.sv
module eeprom_seq #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int MAX_POLLS = 500,
  parameter bit WIDE      = 1'b0,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             cmd_valid,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_write,
  output logic             cmd_read,
  output logic             cmd_nack,
  output logic [7:0]       cmd_byte,
  input  logic             core_tip,
  input  logic             core_rxack,
  input  logic             core_al,
  input  logic [7:0]       core_rdata
);
  localparam int DEV_BYTES = WIDE ? 32768 : 2048;
  localparam int PAGE      = WIDE ? 64 : 16;
  localparam int DEV_SH    = WIDE ? 14 : 7;
  localparam int KHZ       = CLK_HZ / 1000;
  localparam int BASE_CYC  = (KHZ * 32 / 1000 < 1) ? 1 : KHZ * 32 / 1000;
  localparam int PROG_CYC  = (KHZ * 6 < 1) ? 1 : KHZ * 6;

  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_POLL, ST_WAIT, ST_PROG, ST_ABORT} st_t;
  typedef enum logic [2:0] {SP_DEVW, SP_AHI, SP_ALO, SP_DEVR, SP_RDB, SP_DATA} sp_t;

  st_t              st;
  sp_t              sp;
  logic             is_wr;
  logic [15:0]      cur_addr;
  logic [LEN_W-1:0] remain, burst;
  logic [15:0]      budget;
  logic [31:0]      dly, cnt;

  function automatic logic [LEN_W-1:0] burst_of(input logic [15:0] a, input logic [LEN_W-1:0] n);
    int room;
    room = PAGE - int'(a & 16'(PAGE - 1));
    return (int'(n) < room) ? n : LEN_W'(room);
  endfunction

  wire [7:0] dev_base = 8'hA0 | (8'(cur_addr >> DEV_SH) & 8'h0E);
  wire       ack_ok   = (sp == SP_RDB) ? core_rxack : !core_rxack;
  wire       refuse   = req_write ? (req_len == '0 || (32'(req_addr) + 32'(req_len)) > 32'(DEV_BYTES))
                                  : (32'(req_addr) >= 32'(DEV_BYTES));

  assign cmd_valid = (st == ST_CMD) || (st == ST_ABORT);
  assign wr_take   = (st == ST_CMD) && (sp == SP_DATA);
  assign busy      = (st != ST_IDLE);

  always_comb begin
    {cmd_start, cmd_stop, cmd_write, cmd_read, cmd_nack} = 5'b0;
    cmd_byte = 8'h00;
    if (st == ST_ABORT) cmd_stop = 1'b1;
    else if (st == ST_CMD) begin
      case (sp)
        SP_DEVW: begin cmd_start = 1'b1; cmd_write = 1'b1; cmd_byte = dev_base; end
        SP_DEVR: begin cmd_start = 1'b1; cmd_write = 1'b1; cmd_byte = dev_base | 8'h01; end
        SP_AHI:  begin cmd_write = 1'b1; cmd_byte = cur_addr[15:8]; end
        SP_ALO:  begin cmd_write = 1'b1; cmd_byte = cur_addr[7:0]; end
        SP_RDB:  begin cmd_read = 1'b1; cmd_nack = 1'b1; cmd_stop = 1'b1; end
        default: begin cmd_write = 1'b1; cmd_stop = (burst == LEN_W'(1)); cmd_byte = wr_data; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sp <= SP_DEVW; is_wr <= 1'b0; cur_addr <= '0;
      remain <= '0; burst <= '0; budget <= '0; dly <= '0; cnt <= '0;
      rd_data <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          cur_addr <= req_addr; remain <= req_len; is_wr <= req_write;
          sp <= SP_DEVW; burst <= burst_of(req_addr, req_len);
          if (refuse) begin done <= 1'b1; err <= 1'b1; end
          else st <= ST_CMD;
        end
        ST_CMD: begin
          st <= ST_POLL; budget <= 16'(MAX_POLLS); dly <= 32'(BASE_CYC);
        end
        ST_POLL: begin
          if (core_al) st <= ST_ABORT;
          else if (!core_tip && ack_ok) begin
            st <= ST_CMD;
            case (sp)
              SP_DEVW: sp <= WIDE ? SP_AHI : SP_ALO;
              SP_AHI:  sp <= SP_ALO;
              SP_ALO:  sp <= is_wr ? SP_DATA : SP_DEVR;
              SP_DEVR: sp <= SP_RDB;
              SP_RDB:  begin rd_data <= core_rdata; done <= 1'b1; st <= ST_IDLE; end
              default: begin
                cur_addr <= cur_addr + 16'd1; remain <= remain - 1'b1; burst <= burst - 1'b1;
                if (burst == LEN_W'(1)) begin st <= ST_PROG; cnt <= 32'(PROG_CYC); end
              end
            endcase
          end else if (budget == '0) st <= ST_ABORT;
          else begin budget <= budget - 16'd1; cnt <= dly; st <= ST_WAIT; end
        end
        ST_WAIT: begin
          if (cnt <= 32'd1) begin
            st <= ST_POLL;
            dly <= dly[31] ? '1 : (dly << 1);
          end else cnt <= cnt - 32'd1;
        end
        ST_PROG: begin
          if (cnt <= 32'd1) begin
            if (remain == '0) begin done <= 1'b1; st <= ST_IDLE; end
            else begin sp <= SP_DEVW; burst <= burst_of(cur_addr, remain); st <= ST_CMD; end
          end else cnt <= cnt - 32'd1;
        end
        default: begin done <= 1'b1; err <= 1'b1; st <= ST_IDLE; end
      endcase
    end
  end

  // R10 R11
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && req_valid && refuse) |=> (done && err && !cmd_valid));
  // R7
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R8
  abort_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_stop && !cmd_write && !cmd_read) |=> (done && err));
  // R2
  dev_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_start) |-> (cmd_byte[7:4] == 4'hA && cmd_write));
  // R4
  take_is_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (cmd_valid && cmd_write && !cmd_start && !cmd_read));
  // R3
  read_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_read) |-> (cmd_nack && cmd_stop));
  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

// File: tb/eeprom_seq_tb_top.sv
module eeprom_seq_tb_top;
  localparam int PROG = 6000;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_len = '0;
  logic [7:0] wr_data, rd_data, cmd_byte;
  logic wr_take, busy, done, err;
  logic cmd_valid, cmd_start, cmd_stop, cmd_write, cmd_read, cmd_nack;
  logic core_tip = 1'b0, core_rxack = 1'b0, core_al = 1'b0, rx_next = 1'b0;
  logic [7:0] rd_val = 8'h00;

  int errors = 0, checks = 0;
  int cyc = 0, log_n = 0, tip_left = 0;
  int tip_lat = 20, nack_idx = -1, al_idx = -1;
  bit stuck_tip = 1'b0;
  logic [12:0] log_f [0:63];
  int log_t [0:63];
  logic [7:0] data_arr [0:31];
  int take_n = 0, take_base = 0, done_t = 0;

  assign wr_data = data_arr[(take_n - take_base) & 31];

  eeprom_seq #(.CLK_HZ(1_000_000), .MAX_POLLS(6), .WIDE(1'b0), .LEN_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .busy(busy), .done(done), .err(err), .cmd_valid(cmd_valid),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_write(cmd_write), .cmd_read(cmd_read),
    .cmd_nack(cmd_nack), .cmd_byte(cmd_byte), .core_tip(core_tip), .core_rxack(core_rxack),
    .core_al(core_al), .core_rdata(rd_val));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_take) take_n <= take_n + 1;
    if (cmd_valid) begin
      log_f[log_n & 63] <= {cmd_start, cmd_stop, cmd_write, cmd_read, cmd_nack, cmd_byte};
      log_t[log_n & 63] <= cyc;
      log_n <= log_n + 1;
      core_tip <= 1'b1;
      tip_left <= tip_lat;
      rx_next <= cmd_read ? cmd_nack : (log_n == nack_idx);
      core_al <= (log_n == al_idx);
    end else if (tip_left > 0) begin
      tip_left <= tip_left - 1;
      if (tip_left == 1 && !stuck_tip) begin
        core_tip <= 1'b0;
        core_rxack <= rx_next;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input bit wr, input int addr, input int len, output int got_err);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 16'(addr); req_len = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 60000 && !done; i++) @(negedge clk);
    done_t = cyc;
    got_err = int'(err);
    @(negedge clk);
  endtask

  function automatic int devb(input int a, input int rw);
    return 32'hA0 | ((a >> 7) & 32'hE) | rw;
  endfunction

  task automatic t_reset;
    chk(!busy && !done && !cmd_valid && !wr_take, "R1 reset idle", int'({busy, done, cmd_valid, wr_take}), 0);
  endtask

  task automatic t_read;
    int b, e;
    tip_lat = 20; rd_val = 8'h5C; b = log_n;
    run_req(1'b0, 'h5A3, 1, e);
    chk(e == 0, "R3 read no error", e, 0);
    chk(rd_data == 8'h5C, "R3 read data", rd_data, 'h5C);
    chk(log_n - b == 4, "R3 command count", log_n - b, 4);
    chk(log_f[b & 63] == 13'(32'h1400 | devb('h5A3, 0)), "R2 device byte write flag", log_f[b & 63], 32'h1400 | devb('h5A3, 0));
    chk(log_f[(b + 1) & 63] == 13'h04A3, "R3 address byte", log_f[(b + 1) & 63], 'h04A3);
    chk(log_f[(b + 2) & 63] == 13'h14AB, "R2 device byte read flag", log_f[(b + 2) & 63], 'h14AB);
    chk(log_f[(b + 3) & 63] == 13'h0B00, "R3 read with nack and stop", log_f[(b + 3) & 63], 'h0B00);
    chk(log_t[(b + 1) & 63] - log_t[b & 63] > tip_lat, "R7 waits for transfer end",
        log_t[(b + 1) & 63] - log_t[b & 63], tip_lat + 1);
  endtask

  task automatic t_slow;
    int b, e, g;
    tip_lat = 110; b = log_n;
    run_req(1'b0, 'h010, 1, e);
    g = log_t[(b + 1) & 63] - log_t[b & 63];
    chk(g >= 215 && g <= 245, "R8 doubling backoff spacing", g, 229);
    chk(e == 0, "R8 slow transfer succeeds", e, 0);
    tip_lat = 20;
  endtask

  task automatic t_write(input int addr, input int len);
    int b, e, a, rem, k, idx, n, ex;
    for (int i = 0; i < 32; i++) data_arr[i] = 8'(8'h30 + i);
    b = log_n; take_base = take_n;
    run_req(1'b1, addr, len, e);
    chk(e == 0, "R4 write no error", e, 0);
    chk(take_n - take_base == len, "R4 bytes taken", take_n - take_base, len);
    a = addr; rem = len; k = 0; idx = b;
    while (rem > 0) begin
      n = 16 - (a & 15);
      if (rem < n) n = rem;
      if (idx != b)
        chk(log_t[idx & 63] - log_t[(idx - 1) & 63] >= PROG, "R6 programming wait between bursts",
            log_t[idx & 63] - log_t[(idx - 1) & 63], PROG);
      ex = 32'h1400 | devb(a, 0);
      chk(log_f[idx & 63] == 13'(ex), "R2 burst device byte", log_f[idx & 63], ex);
      ex = 32'h0400 | (a & 255);
      chk(log_f[(idx + 1) & 63] == 13'(ex), "R5 burst address byte", log_f[(idx + 1) & 63], ex);
      for (int j = 0; j < n; j++) begin
        ex = ((j == n - 1) ? 32'h0C00 : 32'h0400) | ((32'h30 + k + j) & 255);
        chk(log_f[(idx + 2 + j) & 63] == 13'(ex), "R4 data byte and stop", log_f[(idx + 2 + j) & 63], ex);
      end
      idx += n + 2; a += n; k += n; rem -= n;
    end
    chk(log_n == idx, "R5 total commands", log_n - b, idx - b);
    chk(done_t - log_t[(idx - 1) & 63] >= PROG, "R6 wait before done", done_t - log_t[(idx - 1) & 63], PROG);
  endtask

  task automatic t_nack;
    int b, e, g;
    b = log_n; nack_idx = b + 2; take_base = take_n;
    run_req(1'b1, 'h040, 3, e);
    nack_idx = -1;
    chk(e == 1, "R8 missing ack gives error", e, 1);
    chk(log_n - b == 4, "R8 stops after nack", log_n - b, 4);
    chk(log_f[(b + 3) & 63] == 13'h0800, "R8 stop-only abort", log_f[(b + 3) & 63], 'h0800);
    g = log_t[(b + 3) & 63] - log_t[(b + 2) & 63];
    chk(g >= 2000 && g <= 2060, "R8 nack retries use budget", g, 2024);
  endtask

  task automatic t_stuck;
    int b, e, g;
    b = log_n; stuck_tip = 1'b1;
    run_req(1'b0, 'h100, 1, e);
    stuck_tip = 1'b0;
    chk(e == 1, "R8 timeout error", e, 1);
    chk(log_n - b == 2 && log_f[(b + 1) & 63] == 13'h0800, "R8 timeout stop-only", log_f[(b + 1) & 63], 'h0800);
    g = log_t[(b + 1) & 63] - log_t[b & 63];
    chk(g >= 2000 && g <= 2060, "R8 timeout duration", g, 2024);
  endtask

  task automatic t_al;
    int b, e;
    b = log_n; al_idx = b + 1;
    run_req(1'b0, 'h022, 1, e);
    al_idx = -1;
    chk(e == 1, "R9 arbitration loss error", e, 1);
    chk(log_n - b == 3 && log_f[(b + 2) & 63] == 13'h0800, "R9 stop after arbitration loss", log_f[(b + 2) & 63], 'h0800);
    chk(log_t[(b + 2) & 63] - log_t[(b + 1) & 63] == 2, "R9 abort timing",
        log_t[(b + 2) & 63] - log_t[(b + 1) & 63], 2);
  endtask

  task automatic t_refuse;
    int b, e, t0;
    b = log_n; t0 = cyc;
    run_req(1'b0, 'h800, 1, e);
    chk(e == 1 && log_n == b, "R10 read out of range refused", log_n - b, 0);
    chk(done_t - t0 <= 3, "R10 refusal is immediate", done_t - t0, 2);
    run_req(1'b1, 'h7FE, 4, e);
    chk(e == 1 && log_n == b, "R11 write past end refused", log_n - b, 0);
    run_req(1'b1, 'h100, 0, e);
    chk(e == 1 && log_n == b, "R11 zero-length write refused", log_n - b, 0);
    rd_val = 8'hE7;
    run_req(1'b0, 'h7FF, 1, e);
    chk(e == 0 && rd_data == 8'hE7, "R10 idle again after refusal", rd_data, 'hE7);
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog: actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) data_arr[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_read;
    t_slow;
    t_write('h00E, 20);
    t_write('h3FE, 4);
    t_nack;
    t_stuck;
    t_al;
    t_refuse;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule